// File: doc/BRIEF.md
# Two-Step Column Redundancy Remapper

This block keeps a page byte stream running at full rate even though some columns of the page are defective. On a load, every byte of the page is written into a regular page buffer in column order at one byte per accepted cycle. This includes bytes that land on defective columns, so the stream never waits. Once the last byte is in, a hidden background pass copies only the bytes at defective columns into a small spare zone. Each defect table entry owns one spare slot.

A read runs the same two steps in reverse. First, the spare slots are copied back over the defective columns of the regular buffer. Then the whole page is streamed out on consecutive cycles. The defect table is supplied at the ports as a list of ascending column addresses, each with a valid bit. It is captured when a load or read is accepted. A busy flag covers the whole operation, and start strobes that arrive while it is high are dropped.

Top module: `redun_remap`

## Requirements
- R1: During and after reset, `busy` and `out_valid` are low.
- R2: After an accepted load start, every cycle with `in_valid` high stores `in_byte` at the next column, starting at column 0. No cycle is stalled, and gaps in `in_valid` are allowed.
- R3: In a load, `busy` stays high after the edge that takes the last byte for exactly V more cycles, where V is the number of valid defect entries, and then falls.
- R4: For a read accepted at edge 0, `busy` is high after edges 0 through V+PAGE_COLS-1. `out_valid` is high after edges V+1 through V+PAGE_COLS inclusive, carrying columns 0 upward one per cycle, and is low otherwise.
- R5: A read outputs, at each column named by a valid entry, the content of that entry's spare slot. Every other column returns the regular buffer content.
- R6: Spare slot k belongs to table entry k. A load writes the byte of column `defect_col[k*COL_W +: COL_W]` into slot k when `defect_valid[k]` is 1.
- R7: An entry with `defect_valid[k]` = 0 takes no copy cycle. Its spare slot and its column are left untouched in both directions.
- R8: `wr_start` and `rd_start` are ignored while `busy` is high. The running operation keeps its timing, and no further operation follows it.
- R9: When `wr_start` and `rd_start` are both high while idle, the load is started and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Start a load (stream in, then copy to spares) |
| rd_start | input | 1 | Start a read (copy from spares, then stream out) |
| in_valid | input | 1 | Input byte present this cycle |
| in_byte | input | DATA_W | Input byte |
| defect_valid | input | SPARE_SLOTS | Valid bit per defect table entry |
| defect_col | input | SPARE_SLOTS*COL_W | Ascending defective column addresses, entry k at bits k*COL_W |
| busy | output | 1 | Operation in progress |
| out_valid | output | 1 | Output byte present this cycle |
| out_byte | output | DATA_W | Output byte |

## Verification
The bench builds the block with a 32-column page, eight spare slots and 8-bit data. With this size, a full table can name both end columns, and a whole stream plus copy pass fits in a few dozen cycles.

The page is small enough that random column picks often hit neighbouring and edge columns. At the same time, eight slots make full, empty and sparse valid masks all likely. One load is followed by a second load with an empty table, which leaves the spares holding older data. A read with the first table must then return a visibly mixed page, and that mix is only possible if both copy directions and slot ownership work.

// File: rtl/redun_pkg.sv
package redun_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD,
    PH_SPILL,
    PH_FILL,
    PH_DRAIN
  } phase_t;
endpackage

// File: rtl/redun_pick.sv
// Lowest pending entry selector.
module redun_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign onehot = req & (~req + 1'b1);
  assign any    = |req;
endmodule

// File: rtl/redun_seq.sv
// Phase sequencer: stream pointer, table snapshot, copy scan.
module redun_seq
  import redun_pkg::*;
#(
  parameter int PAGE = 64,
  parameter int N    = 8,
  parameter int AW   = 6,
  parameter int IW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_start,
  input  logic            rd_start,
  input  logic            in_valid,
  input  logic [N-1:0]    tbl_valid,
  input  logic [N*AW-1:0] tbl_col,
  output phase_t          phase,
  output logic [AW-1:0]   ptr,
  output logic            busy,
  output logic [IW-1:0]   slot,
  output logic [AW-1:0]   slot_col
);
  localparam logic [AW-1:0] LAST = AW'(PAGE - 1);

  logic [AW-1:0] snap_col [N];
  logic [N-1:0]  pend;
  logic [N-1:0]  lowbit;
  logic          any;
  logic          last_copy;
  logic          take;
  phase_t        nxt;

  redun_pick #(.N(N)) u_pick (
    .req   (pend),
    .any   (any),
    .idx   (slot),
    .onehot(lowbit)
  );

  assign slot_col  = snap_col[slot];
  assign last_copy = (pend & ~lowbit) == '0;
  assign take      = (phase == PH_IDLE) && (wr_start || rd_start);

  generate
    for (genvar k = 0; k < N; k++) begin : g_snap
      always_ff @(posedge clk) begin
        if (take) snap_col[k] <= tbl_col[k*AW +: AW];
      end
    end
  endgenerate

  always_comb begin
    nxt = phase;
    case (phase)
      PH_IDLE: begin
        if (wr_start)      nxt = PH_LOAD;
        else if (rd_start) nxt = (|tbl_valid) ? PH_FILL : PH_DRAIN;
      end
      PH_LOAD:  if (in_valid && ptr == LAST) nxt = any ? PH_SPILL : PH_IDLE;
      PH_SPILL: if (last_copy) nxt = PH_IDLE;
      PH_FILL:  if (last_copy) nxt = PH_DRAIN;
      PH_DRAIN: if (ptr == LAST) nxt = PH_IDLE;
      default:  nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      busy  <= 1'b0;
      ptr   <= '0;
      pend  <= '0;
    end else begin
      phase <= nxt;
      busy  <= (nxt != PH_IDLE);
      case (phase)
        PH_IDLE: begin
          ptr <= '0;
          if (take) pend <= tbl_valid;
        end
        PH_LOAD: if (in_valid) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        PH_SPILL, PH_FILL: begin
          pend <= pend & ~lowbit;
          ptr  <= '0;
        end
        PH_DRAIN: ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        default: ptr <= '0;
      endcase
    end
  end

  // R2
  load_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOAD && in_valid && ptr != LAST) |=> (phase == PH_LOAD && ptr == $past(ptr) + 1'b1));

  // R4
  drain_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DRAIN && ptr != LAST) |=> (phase == PH_DRAIN && busy));

  // R8
  load_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOAD && rd_start) |=> (phase != PH_FILL && phase != PH_DRAIN));

  // R3
  copy_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SPILL || phase == PH_FILL) |-> (pend != '0 && busy));
endmodule

// File: rtl/redun_store.sv
// Regular page buffer (one write port) and spare zone.
module redun_store
  import redun_pkg::*;
#(
  parameter int PAGE = 64,
  parameter int N    = 8,
  parameter int DW   = 8,
  parameter int AW   = 6,
  parameter int IW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_t        phase,
  input  logic [AW-1:0] ptr,
  input  logic [IW-1:0] slot,
  input  logic [AW-1:0] slot_col,
  input  logic          in_valid,
  input  logic [DW-1:0] in_byte,
  output logic          out_valid,
  output logic [DW-1:0] out_byte
);
  logic [DW-1:0] page_mem [PAGE];
  logic [DW-1:0] spare    [N];

  logic          wr_en;
  logic [AW-1:0] wr_a;
  logic [DW-1:0] wr_d;

  assign wr_en = (phase == PH_LOAD && in_valid) || (phase == PH_FILL);
  assign wr_a  = (phase == PH_FILL) ? slot_col : ptr;
  assign wr_d  = (phase == PH_FILL) ? spare[slot] : in_byte;

  always_ff @(posedge clk) begin
    if (wr_en) page_mem[wr_a] <= wr_d;
  end

  always_ff @(posedge clk) begin
    if (phase == PH_SPILL) spare[slot] <= page_mem[slot_col];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      out_valid <= (phase == PH_DRAIN);
      if (phase == PH_DRAIN) out_byte <= page_mem[ptr];
    end
  end

  // R4
  out_run_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |=> out_valid);
endmodule

// File: rtl/redun_remap.sv
module redun_remap
  import redun_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PAGE_COLS   = 64,
  parameter int SPARE_SLOTS = 8,
  localparam int COL_W  = (PAGE_COLS > 1) ? $clog2(PAGE_COLS) : 1,
  localparam int SLOT_W = (SPARE_SLOTS > 1) ? $clog2(SPARE_SLOTS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_start,
  input  logic                         rd_start,
  input  logic                         in_valid,
  input  logic [DATA_W-1:0]            in_byte,
  input  logic [SPARE_SLOTS-1:0]       defect_valid,
  input  logic [SPARE_SLOTS*COL_W-1:0] defect_col,
  output logic                         busy,
  output logic                         out_valid,
  output logic [DATA_W-1:0]            out_byte
);
  phase_t              phase;
  logic [COL_W-1:0]    ptr;
  logic [SLOT_W-1:0]   slot;
  logic [COL_W-1:0]    slot_col;

  redun_seq #(
    .PAGE(PAGE_COLS), .N(SPARE_SLOTS), .AW(COL_W), .IW(SLOT_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .wr_start (wr_start),
    .rd_start (rd_start),
    .in_valid (in_valid),
    .tbl_valid(defect_valid),
    .tbl_col  (defect_col),
    .phase    (phase),
    .ptr      (ptr),
    .busy     (busy),
    .slot     (slot),
    .slot_col (slot_col)
  );

  redun_store #(
    .PAGE(PAGE_COLS), .N(SPARE_SLOTS), .DW(DATA_W), .AW(COL_W), .IW(SLOT_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase),
    .ptr      (ptr),
    .slot     (slot),
    .slot_col (slot_col),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .out_valid(out_valid),
    .out_byte (out_byte)
  );
endmodule

// File: tb/sim_redun_remap.sv
`timescale 1ns/1ps
module sim_redun_remap;
  localparam int PAGE = 32;
  localparam int N    = 8;
  localparam int DW   = 8;
  localparam int AW   = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_start = 1'b0;
  logic rd_start = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0]   in_byte = '0;
  logic [N-1:0]    defect_valid = '0;
  logic [N*AW-1:0] defect_col = '0;
  wire             busy;
  wire             out_valid;
  wire  [DW-1:0]   out_byte;

  always #2.5 clk = ~clk;

  redun_remap #(.DATA_W(DW), .PAGE_COLS(PAGE), .SPARE_SLOTS(N)) u0 (
    .clk(clk), .rst(rst), .wr_start(wr_start), .rd_start(rd_start),
    .in_valid(in_valid), .in_byte(in_byte),
    .defect_valid(defect_valid), .defect_col(defect_col),
    .busy(busy), .out_valid(out_valid), .out_byte(out_byte)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [DW-1:0] m_page  [PAGE];
  logic [DW-1:0] m_spare [N];
  logic [DW-1:0] data    [PAGE];
  int            tcol    [N];
  logic [N-1:0]  tval;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_table();
    for (int k = 0; k < N; k++) defect_col[k*AW +: AW] = AW'(tcol[k]);
    defect_valid = tval;
  endtask

  // ascending distinct columns; optionally forcing both end columns
  task automatic pick_cols(input bit ends);
    logic [PAGE-1:0] cm;
    int n, c, k;
    cm = '0;
    n  = 0;
    if (ends) begin
      cm[0] = 1'b1;
      cm[PAGE-1] = 1'b1;
      n = 2;
    end
    while (n < N) begin
      c = int'($urandom_range(PAGE - 1));
      if (!cm[c]) begin
        cm[c] = 1'b1;
        n++;
      end
    end
    k = 0;
    for (int i = 0; i < PAGE; i++) if (cm[i]) begin
      tcol[k] = i;
      k++;
    end
  endtask

  task automatic do_load(input bit both, input bit inj, input bit gaps);
    int v;
    v = $countones(tval);
    for (int i = 0; i < PAGE; i++) data[i] = DW'($urandom);
    @(negedge clk);
    put_table();
    wr_start = 1'b1;
    rd_start = both;
    @(negedge clk);
    wr_start = 1'b0;
    rd_start = 1'b0;
    chk(busy == 1'b1, "R2 busy after load start", int'(busy), 1);
    for (int i = 0; i < PAGE; i++) begin
      if (gaps) begin
        while ($urandom_range(3) == 0) begin
          in_valid = 1'b0;
          @(negedge clk);
        end
      end
      in_valid = 1'b1;
      in_byte  = data[i];
      if (inj && i == 4) rd_start = 1'b1;
      @(negedge clk);
      rd_start = 1'b0;
    end
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R9 load taken, no output", int'(out_valid), 0);
    for (int i = 0; i <= v; i++) begin
      chk(busy == (i < v), "R3 R8 copy-in busy window", int'(busy), int'(i < v));
      if (i < v) @(negedge clk);
    end
    // R6 R7: slot k takes its column only when valid
    for (int i = 0; i < PAGE; i++) m_page[i] = data[i];
    for (int k = 0; k < N; k++) if (tval[k]) m_spare[k] = data[tcol[k]];
  endtask

  task automatic do_read(input bit inj);
    int v;
    bit ev;
    v = $countones(tval);
    @(negedge clk);
    put_table();
    rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
    chk(busy == 1'b1, "R4 busy after read start", int'(busy), 1);
    for (int k = 0; k < N; k++) if (tval[k]) m_page[tcol[k]] = m_spare[k];
    for (int t = 1; t <= v + PAGE + 1; t++) begin
      @(negedge clk);
      wr_start = 1'b0;
      ev = (t >= v + 1) && (t <= v + PAGE);
      chk(out_valid == ev, "R4 out_valid timing", int'(out_valid), int'(ev));
      if (ev)
        chk(out_byte == m_page[t-v-1], "R5 R6 R7 output byte", int'(out_byte), int'(m_page[t-v-1]));
      chk(busy == (t < v + PAGE), "R4 R8 read busy window", int'(busy), int'(t < v + PAGE));
      if (inj && t == v + 5) wr_start = 1'b1;
    end
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);

    // full table with both end columns; simultaneous starts and a stray read strobe
    pick_cols(1'b1);
    tval = 8'hFF;
    do_load(1'b1, 1'b1, 1'b0);
    // second page, empty table: spares keep first page bytes
    tval = 8'h00;
    do_load(1'b0, 1'b0, 1'b1);
    // read with full table: mixed page expected, stray load strobe
    tval = 8'hFF;
    do_read(1'b1);
    // empty table read: no copy cycles
    tval = 8'h00;
    do_read(1'b0);
    // sparse mask: only some slots refreshed
    pick_cols(1'b0);
    tval = 8'hA5;
    do_load(1'b0, 1'b0, 1'b0);
    tval = 8'hFF;
    do_read(1'b0);

    for (int r = 0; r < 10; r++) begin
      pick_cols(1'($urandom_range(1)));
      tval = N'($urandom);
      if ($urandom_range(1) == 1) do_load(1'b0, 1'($urandom_range(1)), 1'b1);
      else do_read(1'($urandom_range(1)));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule